// File: doc/BRIEF.md
# Timer Event Capture Unit

This block records the moment an event happens. A free-running timer count comes in from outside. When the chosen edge appears on the chosen trigger, the block copies that count into a capture register and raises a capture flag. The flag can drive an interrupt request. Software clears it by writing a one, or the interrupt controller clears it by pulsing an acknowledge.

There are two trigger inputs: a pin-side input and an internal event input. Each passes through its own synchronizer, and then a select bit picks one. Because the selection is made after synchronization, changing the select bit can by itself produce an edge and a capture. An optional filter can be switched in on the system clock. It passes a new level only after four consecutive samples agree, which rejects short glitches and adds four cycles of latency. The edge polarity can be changed between captures, so alternating edges gives high and low times for duty-cycle measurement.

Top module: `icap_unit`

## Requirements
- R1: After reset the capture register reads 0 and both the flag and the interrupt request read 0.
- R2: With `edge_rise_i`=1 only a low-to-high transition of the selected trigger captures, and with `edge_rise_i`=0 only a high-to-low transition captures; the opposite transition leaves the capture register and the flag unchanged.
- R3: With the filter off, a trigger change that the bench drives between edges is captured on the third rising clock edge after it. The register takes the value `count_i` holds at that edge.
- R4: The flag becomes 1 on the same clock edge on which the capture register is loaded.
- R5: `irq_o` is 1 exactly when the flag is 1 and `irq_en_i` is 1.
- R6: A one on `flag_clr_i` at a clock edge clears the flag. If a capture happens on the same edge, the flag stays 1.
- R7: A one on `irq_ack_i` at a clock edge clears the flag, with the same priority rule as R6.
- R8: `src_sel_i`=0 selects `trig_pin_i` and `src_sel_i`=1 selects `trig_alt_i`; the unselected input has no effect. A select change that makes the selected level move in the active direction captures on the next clock edge.
- R9: With `filt_en_i`=1, a trigger level that lasts fewer than four clock cycles causes no capture.
- R10: With `filt_en_i`=1, a level that lasts four or more cycles is captured four edges later than in R3, on the seventh edge after the change.
- R11: A second event overwrites the capture register even when the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (undivided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Free-running timer count |
| trig_pin_i | input | 1 | Pin-side trigger (source 0) |
| trig_alt_i | input | 1 | Internal event trigger (source 1) |
| src_sel_i | input | 1 | Trigger source select |
| edge_rise_i | input | 1 | 1 = rising edge, 0 = falling edge |
| filt_en_i | input | 1 | Enable four-sample filter |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse, clears the flag |
| cap_o | output | CNT_W | Captured count |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a capture caused only by switching the source select. To set it up, the unselected input is held at the active level while the selected one stays idle. The bench waits until both synchronizers have settled, checks that no capture has occurred, and then toggles only the select bit. It expects a capture one edge later. The next hardest case is the filter boundary: directed pulses of exactly three and exactly four cycles separate rejection from acceptance. The random rounds mix polarity, filter state and pulse width.

// File: rtl/icap_pkg.sv
package icap_pkg;
   localparam int ICAP_CNT_W       = 16;
   localparam int ICAP_SYNC_STAGES = 2;
   localparam int ICAP_FILT_SAMPLES = 4;

   typedef enum logic {
      SRC_PIN = 1'b0,
      SRC_ALT = 1'b1
   } icap_src_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
   parameter int SAMPLES = 4,
   parameter bit PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic d_i,
   output logic q_o
);
   localparam int HIST_W = SAMPLES - 1;

   if (SAMPLES < 2) begin : g_bad_samples
      $error("icap_filter: SAMPLES must be at least 2");
   end

   if (PRESENT) begin : g_filter
      logic [HIST_W-1:0] hist_q;
      logic              level_q;
      logic              agree;

      assign agree = (hist_q == {HIST_W{d_i}});

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hist_q  <= '0;
            level_q <= 1'b0;
         end else begin
            hist_q <= {hist_q[HIST_W-1:0], d_i} [HIST_W-1:0];
            if (!en_i || agree) level_q <= d_i;
         end
      end

      assign q_o = en_i ? level_q : d_i;

      // R9: a filtered level changes only once the whole history agrees with it
      assert_filter_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(en_i) && (level_q != $past(level_q))) |-> (hist_q == {HIST_W{level_q}}));
   end else begin : g_bypass
      assign q_o = d_i;
   end
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   input  logic rise_i,
   output logic hit_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= d_i;
   end

   assign hit_o = rise_i ? (d_i & ~prev_q) : (~d_i & prev_q);
endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int CNT_W          = ICAP_CNT_W,
   parameter int SYNC_STAGES    = ICAP_SYNC_STAGES,
   parameter int FILT_SAMPLES   = ICAP_FILT_SAMPLES,
   parameter bit FILTER_PRESENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic             trig_pin_i,
   input  logic             trig_alt_i,
   input  logic             src_sel_i,
   input  logic             edge_rise_i,
   input  logic             filt_en_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   input  logic             irq_ack_i,
   output logic [CNT_W-1:0] cap_o,
   output logic             flag_o,
   output logic             irq_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("icap_unit: CNT_W must be at least 2");
   end

   logic pin_s, alt_s, sel_lvl, filt_lvl, hit;
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;
   icap_src_e        src;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync_pin (
      .clk(clk), .rst_n(rst_n), .d_i(trig_pin_i), .q_o(pin_s));
   icap_sync #(.STAGES(SYNC_STAGES)) u_sync_alt (
      .clk(clk), .rst_n(rst_n), .d_i(trig_alt_i), .q_o(alt_s));

   assign src     = icap_src_e'(src_sel_i);
   assign sel_lvl = (src == SRC_ALT) ? alt_s : pin_s;

   icap_filter #(.SAMPLES(FILT_SAMPLES), .PRESENT(FILTER_PRESENT)) u_filter (
      .clk(clk), .rst_n(rst_n), .en_i(filt_en_i), .d_i(sel_lvl), .q_o(filt_lvl));

   icap_edge u_edge (
      .clk(clk), .rst_n(rst_n), .d_i(filt_lvl), .rise_i(edge_rise_i), .hit_o(hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (hit) cap_q <= count_i;
         if (hit)                          flag_q <= 1'b1;
         else if (flag_clr_i || irq_ack_i) flag_q <= 1'b0;
      end
   end

   assign cap_o  = cap_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q & irq_en_i;

   // R4: a detected edge loads the count and sets the flag together
   assert_capture_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (flag_q && cap_q == $past(count_i)));
   // R2: without a detected edge the capture register holds
   assert_cap_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(cap_q));
   // R6: write-one-to-clear wins unless a capture coincides
   assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !hit) |=> !flag_q);
   // R7: acknowledge clears the flag unless a capture coincides
   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !hit) |=> !flag_q);
   // R5: no request without a pending flag
   assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_q);
endmodule

// File: tb/sim_icap_unit.sv
`timescale 1ns/1ps
module sim_icap_unit;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tcnt = 16'hFFF0;
   logic         trig_pin = 1'b0, trig_alt = 1'b0, src_sel = 1'b0;
   logic         edge_rise = 1'b1, filt_en = 1'b0, irq_en = 1'b0;
   logic         flag_clr = 1'b0, irq_ack = 1'b0;
   logic [W-1:0] cap;
   logic         flag, irq;

   int checks = 0;
   int failures = 0;

   icap_unit u0 (
      .clk(clk), .rst_n(rst_n), .count_i(tcnt),
      .trig_pin_i(trig_pin), .trig_alt_i(trig_alt), .src_sel_i(src_sel),
      .edge_rise_i(edge_rise), .filt_en_i(filt_en), .irq_en_i(irq_en),
      .flag_clr_i(flag_clr), .irq_ack_i(irq_ack),
      .cap_o(cap), .flag_o(flag), .irq_o(irq));

   always #2.5 clk = ~clk;

   always @(posedge clk) tcnt <= tcnt + 16'd1;

   function automatic logic [W-1:0] exp_cap(input logic [W-1:0] t0, input logic filt);
      return t0 + (filt ? 16'd6 : 16'd2);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_flag();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   logic [W-1:0] t0, t1, held;

   initial begin
      tick(4);
      // R1 reset state
      check("R1 cap", cap, 0);
      check("R1 flag", flag, 0);
      check("R1 irq", irq, 0);
      rst_n = 1'b1;
      tick(3);
      check("R1 idle after release", flag, 0);

      // R3/R4 rising edge, filter off, exact latency
      @(negedge clk) begin trig_pin = 1'b1; t0 = tcnt; end
      tick(2);
      check("R3 no capture before third edge", flag, 0);
      tick(1);
      check("R4 flag on third edge", flag, 1);
      check("R3 captured count", cap, exp_cap(t0, 1'b0));

      // R5 interrupt gating
      check("R5 irq masked", irq, 0);
      irq_en = 1'b1; #0.1;
      check("R5 irq enabled", irq, 1);

      // R6 write-one-to-clear
      clear_flag();
      check("R6 w1c clears", flag, 0);
      check("R5 irq drops with flag", irq, 0);

      // R2 falling edge ignored under rising polarity
      held = cap;
      @(negedge clk) trig_pin = 1'b0;
      tick(8);
      check("R2 opposite edge no flag", flag, 0);
      check("R2 opposite edge cap held", cap, held);

      // R2 falling polarity captures falling edge
      edge_rise = 1'b0;
      @(negedge clk) trig_pin = 1'b1;
      tick(8);
      check("R2 rising ignored when falling selected", flag, 0);
      @(negedge clk) begin trig_pin = 1'b0; t0 = tcnt; end
      tick(3);
      check("R2 falling captured", cap, exp_cap(t0, 1'b0));
      check("R2 falling flag", flag, 1);

      // R7 acknowledge clears
      @(negedge clk) irq_ack = 1'b1;
      @(negedge clk) irq_ack = 1'b0;
      check("R7 ack clears", flag, 0);

      // R6 set beats clear on same edge
      edge_rise = 1'b1;
      @(negedge clk) begin trig_pin = 1'b1; t0 = tcnt; end
      tick(2);
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
      check("R6 capture wins over clear", flag, 1);
      check("R6 capture value", cap, exp_cap(t0, 1'b0));

      // R11 overwrite without clearing
      @(negedge clk) trig_pin = 1'b0;
      tick(5);
      @(negedge clk) begin trig_pin = 1'b1; t1 = tcnt; end
      tick(6);
      check("R11 overwritten", cap, exp_cap(t1, 1'b0));
      check("R11 flag still set", flag, 1);

      // R8 unselected input ignored, then select switch captures
      @(negedge clk) trig_pin = 1'b0;
      tick(6);
      clear_flag();
      held = cap;
      @(negedge clk) trig_alt = 1'b1;
      tick(8);
      check("R8 unselected input ignored", flag, 0);
      check("R8 unselected cap held", cap, held);
      @(negedge clk) begin src_sel = 1'b1; t0 = tcnt; end
      tick(1);
      check("R8 select switch captures", cap, t0);
      check("R8 select switch flag", flag, 1);
      @(negedge clk) begin trig_alt = 1'b0; src_sel = 1'b0; end
      tick(8);
      clear_flag();

      // R9 three-cycle glitch rejected by filter
      filt_en = 1'b1;
      tick(6);
      held = cap;
      @(negedge clk) trig_pin = 1'b1;
      tick(3);
      trig_pin = 1'b0;
      tick(12);
      check("R9 short pulse rejected flag", flag, 0);
      check("R9 short pulse cap held", cap, held);

      // R10 four-cycle pulse accepted with extra latency
      @(negedge clk) begin trig_pin = 1'b1; t0 = tcnt; end
      tick(4);
      trig_pin = 1'b0;
      tick(2);
      check("R10 not yet at sixth edge", flag, 0);
      tick(1);
      check("R10 flag at seventh edge", flag, 1);
      check("R10 filtered capture", cap, exp_cap(t0, 1'b1));
      tick(12);

      // random rounds: R2/R3/R10
      void'($urandom(32'h1CAB5));
      for (int i = 0; i < 60; i++) begin
         logic pol, flt;
         int   hw;
         pol = 1'($urandom_range(0, 1));
         flt = 1'($urandom_range(0, 1));
         hw  = $urandom_range(4, 10);
         @(negedge clk) begin edge_rise = pol; filt_en = flt; trig_pin = ~pol; end
         tick(14);
         clear_flag();
         @(negedge clk) begin trig_pin = pol; t0 = tcnt; end
         tick(hw);
         trig_pin = ~pol;
         tick(12);
         check(flt ? "R10 random capture" : "R3 random capture", cap, exp_cap(t0, flt));
         check("R2 random flag", flag, 1);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #150000;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule